// File: doc/BRIEF.md
# Operator Console Sequencer

This block sits between the switches and push buttons of an operator panel and an 8-bit stored-program computer. It turns momentary button presses into single operations on the machine. Set address copies the data switches into the program counter. Store writes the switch value into memory. Peek reads memory into the buffer register. Start lets the processor run, and Stop halts it. Every press is reduced to a single rising-edge event. A console operation is refused whenever the processor is running.

Run control owns the processor's clock enable. In fast mode a run issues one processor step every clock cycle. In slow mode a terminal-count divider issues one step every `SLOW_DIV` cycles. With the default of 250000, a 500 kHz base clock steps at 2 Hz. Stopping always happens at an instruction boundary, so the program counter is left pointing at the next instruction. In one-shot mode, Start runs exactly one instruction.

The block has two state machines.

The access machine has the states `AC_IDLE`, `AC_LOAD`, `AC_DEP_WRITE`, `AC_DEP_BUMP`, `AC_EXM_READ` and `AC_EXM_TAKE`. Its transitions are:
- idle→load on a set-address press;
- idle→dep_write on a store press;
- idle→exm_read on a peek press;
- load→idle;
- dep_write→dep_bump→idle;
- exm_read→exm_take→idle.

The run machine has the states `RN_STOPPED`, `RN_FREE`, `RN_ONE` and `RN_DRAIN`. Its transitions are:
- stopped→free on Start in continuous mode;
- stopped→one on Start in one-shot mode;
- free→drain on Stop in mid-instruction;
- free→stopped on Stop at an instruction end, or on the end of a halt instruction;
- one→stopped and drain→stopped at the next instruction end.

Top module: `panel_console`

## Requirements
- R1: After reset the machine is stopped: `cpu_run`, `cpu_ce`, every request output and every lamp are 0.
- R2: A set-address press writes `sw_data` into the program counter (`pc_wr_en` with `pc_wr_val` = switches).
- R3: A store press writes `sw_data` to memory at the current PC. It loads MA with that address and then writes PC+1, which wraps from 0xFF to 0x00.
- R4: A peek press reads memory at the current PC into MB. It loads MA with that address and then writes PC+1.
- R5: A press held high for many cycles performs exactly one operation.
- R6: When several console buttons rise in the same cycle, only one operation runs. The priority is set-address, then store, then peek.
- R7: While the machine runs, console presses issue no memory, PC, MA or MB request.
- R8: In continuous fast mode, `cpu_ce` is high on every cycle of the run.
- R9: Stop takes effect only at the step on which `cpu_instr_end` is high. Until then the run continues, and afterwards `cpu_phase` is back at fetch (code 00).
- R10: In one-shot mode, Start runs exactly one whole instruction and then stops.
- R11: In slow mode, `cpu_ce` pulses once every `SLOW_DIV` cycles. The first pulse comes on the `SLOW_DIV`-th running cycle.
- R12: When `cpu_hlt` is high on the final step of an instruction, the run stops after that instruction.
- R13: `led_run` equals `cpu_run`. While running, the phase lamps decode `cpu_phase` as 00 fetch, 01 defer and 10 execute. While stopped, all phase lamps are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_data | input | 8 | Data switches |
| btn_load | input | 1 | Set-address button (debounced level) |
| btn_deposit | input | 1 | Store button |
| btn_examine | input | 1 | Peek button |
| btn_run | input | 1 | Start button |
| btn_halt | input | 1 | Stop button |
| mode_single | input | 1 | 1 = one instruction per Start |
| mode_slow | input | 1 | 1 = divided step rate |
| pc_in | input | 8 | Current program counter from the processor |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |
| cpu_phase | input | 2 | Processor phase: 00 fetch, 01 defer, 10 execute |
| cpu_instr_end | input | 1 | Current phase is the last of the instruction |
| cpu_hlt | input | 1 | Current instruction is a halt |
| pc_wr_en | output | 1 | Program counter write strobe |
| pc_wr_val | output | 8 | Program counter write value |
| ma_wr_en | output | 1 | Address register write strobe |
| ma_wr_val | output | 8 | Address register write value |
| mb_wr_en | output | 1 | Buffer register write strobe |
| mb_wr_val | output | 8 | Buffer register write value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| cpu_run | output | 1 | Processor is in a run |
| cpu_ce | output | 1 | Processor step enable |
| led_run | output | 1 | Run lamp |
| led_fetch | output | 1 | Fetch lamp |
| led_defer | output | 1 | Defer lamp |
| led_exec | output | 1 | Execute lamp |

## Verification
A run machine left in a wrong state shows at `cpu_run` and `cpu_ce` within one cycle. The symptoms are a stop before `cpu_instr_end`, an extra instruction in one-shot mode, or steps at the wrong pacing. Any of these leaves `cpu_phase` away from fetch, or moves the program counter by the wrong amount, by the time the run lamp drops. A wrong access state shows on the next cycle as a missing, doubled or misordered strobe. Typical cases are a PC write without the preceding memory access, a second store from one held press, or a request while running. Each of these leaves a wrong value in the memory, MA, MB or PC model a few cycles after the press.

// File: rtl/panel_console_pkg.sv
package panel_console_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_DEFER = 2'b01,
        PH_EXEC  = 2'b10,
        PH_NONE  = 2'b11
    } cpu_phase_e;

    typedef enum logic [2:0] {
        AC_IDLE,
        AC_LOAD,
        AC_DEP_WRITE,
        AC_DEP_BUMP,
        AC_EXM_READ,
        AC_EXM_TAKE
    } access_state_e;

    typedef enum logic [1:0] {
        RN_STOPPED,
        RN_FREE,
        RN_ONE,
        RN_DRAIN
    } run_state_e;

    localparam int unsigned BTN_N    = 5;
    localparam int unsigned BTN_LOAD = 0;
    localparam int unsigned BTN_DEP  = 1;
    localparam int unsigned BTN_EXM  = 2;
    localparam int unsigned BTN_RUN  = 3;
    localparam int unsigned BTN_HALT = 4;

endpackage

// File: rtl/panel_pulse_detect.sv
module panel_pulse_detect #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] stage_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q <= level;
            prev_q  <= stage_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = stage_q[i] & ~prev_q[i];

        // A held button yields one event only.
        assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/panel_step_divider.sv
module panel_step_divider #(
    parameter int unsigned DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run & (slow ? (cnt_q == LAST) : 1'b1);

    assert_count_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_slow_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slow && tick && $stable(slow)) |=> !(tick && slow));

endmodule

// File: rtl/panel_run_fsm.sv
module panel_run_fsm
    import panel_console_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_rise,
    input  logic halt_rise,
    input  logic single,
    input  logic busy,
    input  logic step,
    input  logic instr_end,
    input  logic hlt_instr,
    output logic running
);
    run_state_e state_q, state_d;
    logic       boundary;

    assign boundary = step & instr_end;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RN_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RN_STOPPED: begin
                if (run_rise && !busy) state_d = single ? RN_ONE : RN_FREE;
            end
            RN_FREE: begin
                if (boundary && (hlt_instr || halt_rise)) state_d = RN_STOPPED;
                else if (halt_rise)                       state_d = RN_DRAIN;
            end
            RN_ONE: begin
                if (boundary) state_d = RN_STOPPED;
            end
            RN_DRAIN: begin
                if (boundary) state_d = RN_STOPPED;
            end
            default: state_d = RN_STOPPED;
        endcase
    end

    always_comb begin
        running = (state_q != RN_STOPPED);
    end

    // Runs end only on the final step of an instruction.
    assert_stop_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(step && instr_end));

    assert_start_on_press_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(run_rise && !busy));

    assert_halt_instr_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step && instr_end && hlt_instr) |=> !running);

endmodule

// File: rtl/panel_access_fsm.sv
module panel_access_fsm
    import panel_console_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_load,
    input  logic          rise_dep,
    input  logic          rise_exm,
    input  logic          running,
    input  logic [DW-1:0] sw,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          pc_wr_en,
    output logic [DW-1:0] pc_wr_val,
    output logic          ma_wr_en,
    output logic [DW-1:0] ma_wr_val,
    output logic          mb_wr_en,
    output logic [DW-1:0] mb_wr_val,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    access_state_e state_q, state_d;
    logic          accept;

    assign accept = (state_q == AC_IDLE) && !running;
    assign busy   = (state_q != AC_IDLE) ||
                    (!running && (rise_load || rise_dep || rise_exm));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AC_IDLE: begin
                if (accept) begin
                    if (rise_load)     state_d = AC_LOAD;
                    else if (rise_dep) state_d = AC_DEP_WRITE;
                    else if (rise_exm) state_d = AC_EXM_READ;
                end
            end
            AC_LOAD:      state_d = AC_IDLE;
            AC_DEP_WRITE: state_d = AC_DEP_BUMP;
            AC_DEP_BUMP:  state_d = AC_IDLE;
            AC_EXM_READ:  state_d = AC_EXM_TAKE;
            AC_EXM_TAKE:  state_d = AC_IDLE;
            default:      state_d = AC_IDLE;
        endcase
    end

    always_comb begin
        pc_wr_en  = 1'b0;
        pc_wr_val = '0;
        ma_wr_en  = 1'b0;
        ma_wr_val = '0;
        mb_wr_en  = 1'b0;
        mb_wr_val = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            AC_IDLE: ;
            AC_LOAD: begin
                pc_wr_en  = 1'b1;
                pc_wr_val = sw;
            end
            AC_DEP_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pc_in;
                mem_wdata = sw;
                ma_wr_en  = 1'b1;
                ma_wr_val = pc_in;
            end
            AC_DEP_BUMP: begin
                pc_wr_en  = 1'b1;
                pc_wr_val = pc_in + 1'b1;
            end
            AC_EXM_READ: begin
                mem_req   = 1'b1;
                mem_addr  = pc_in;
                ma_wr_en  = 1'b1;
                ma_wr_val = pc_in;
            end
            AC_EXM_TAKE: begin
                mb_wr_en  = 1'b1;
                mb_wr_val = mem_rdata;
                pc_wr_en  = 1'b1;
                pc_wr_val = pc_in + 1'b1;
            end
            default: ;
        endcase
    end

    assert_console_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != AC_IDLE) |-> !running);

    assert_store_then_bump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (pc_wr_en && !mem_req));

    assert_read_then_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mb_wr_en && pc_wr_en));

endmodule

// File: rtl/panel_console.sv
module panel_console
    import panel_console_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SLOW_DIV = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              btn_load,
    input  logic              btn_deposit,
    input  logic              btn_examine,
    input  logic              btn_run,
    input  logic              btn_halt,
    input  logic              mode_single,
    input  logic              mode_slow,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [1:0]        cpu_phase,
    input  logic              cpu_instr_end,
    input  logic              cpu_hlt,
    output logic              pc_wr_en,
    output logic [DATA_W-1:0] pc_wr_val,
    output logic              ma_wr_en,
    output logic [DATA_W-1:0] ma_wr_val,
    output logic              mb_wr_en,
    output logic [DATA_W-1:0] mb_wr_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cpu_run,
    output logic              cpu_ce,
    output logic              led_run,
    output logic              led_fetch,
    output logic              led_defer,
    output logic              led_exec
);
    logic [BTN_N-1:0] btn_level;
    logic [BTN_N-1:0] btn_rise;
    logic             busy;
    logic             running;
    logic             tick;

    assign btn_level[BTN_LOAD] = btn_load;
    assign btn_level[BTN_DEP]  = btn_deposit;
    assign btn_level[BTN_EXM]  = btn_examine;
    assign btn_level[BTN_RUN]  = btn_run;
    assign btn_level[BTN_HALT] = btn_halt;

    panel_pulse_detect #(.N(BTN_N)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .level (btn_level),
        .rise  (btn_rise)
    );

    panel_step_divider #(.DIV(SLOW_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .slow  (mode_slow),
        .tick  (tick)
    );

    panel_run_fsm u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_rise  (btn_rise[BTN_RUN]),
        .halt_rise (btn_rise[BTN_HALT]),
        .single    (mode_single),
        .busy      (busy),
        .step      (tick),
        .instr_end (cpu_instr_end),
        .hlt_instr (cpu_hlt),
        .running   (running)
    );

    panel_access_fsm #(.DW(DATA_W)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_load (btn_rise[BTN_LOAD]),
        .rise_dep  (btn_rise[BTN_DEP]),
        .rise_exm  (btn_rise[BTN_EXM]),
        .running   (running),
        .sw        (sw_data),
        .pc_in     (pc_in),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .pc_wr_en  (pc_wr_en),
        .pc_wr_val (pc_wr_val),
        .ma_wr_en  (ma_wr_en),
        .ma_wr_val (ma_wr_val),
        .mb_wr_en  (mb_wr_en),
        .mb_wr_val (mb_wr_val),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign cpu_run   = running;
    assign cpu_ce    = tick;
    assign led_run   = running;
    assign led_fetch = running && (cpu_phase == PH_FETCH);
    assign led_defer = running && (cpu_phase == PH_DEFER);
    assign led_exec  = running && (cpu_phase == PH_EXEC);

    // The access sequencer and the run sequencer never drive the machine together.
    assert_no_access_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> !(mem_req || pc_wr_en || ma_wr_en || mb_wr_en));

    assert_step_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_run |=> !cpu_ce || cpu_run);

endmodule

// File: tb/panel_console_test.sv
module panel_console_test;
    localparam int DIV = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic [7:0] sw_data;
    logic       btn_load, btn_deposit, btn_examine, btn_run, btn_halt;
    logic       mode_single, mode_slow;
    logic [7:0] pc_m, ma_m, mb_m, rdata_m;
    logic [1:0] phase_m;
    logic       cpu_instr_end, cpu_hlt;
    logic       pc_wr_en, ma_wr_en, mb_wr_en, mem_req, mem_we;
    logic [7:0] pc_wr_val, ma_wr_val, mb_wr_val, mem_addr, mem_wdata;
    logic       cpu_run, cpu_ce, led_run, led_fetch, led_defer, led_exec;

    logic [7:0] mem [256];
    logic       defer_mode, hlt_arm;
    int         instr_done, console_acts;
    int         total = 0, bad = 0;
    bit         finished = 0;

    assign cpu_instr_end = (phase_m == 2'b10);
    assign cpu_hlt       = hlt_arm && cpu_instr_end;

    panel_console #(.DATA_W(8), .SLOW_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .sw_data(sw_data),
        .btn_load(btn_load), .btn_deposit(btn_deposit), .btn_examine(btn_examine),
        .btn_run(btn_run), .btn_halt(btn_halt),
        .mode_single(mode_single), .mode_slow(mode_slow),
        .pc_in(pc_m), .mem_rdata(rdata_m), .cpu_phase(phase_m),
        .cpu_instr_end(cpu_instr_end), .cpu_hlt(cpu_hlt),
        .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val),
        .ma_wr_en(ma_wr_en), .ma_wr_val(ma_wr_val),
        .mb_wr_en(mb_wr_en), .mb_wr_val(mb_wr_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cpu_run(cpu_run), .cpu_ce(cpu_ce),
        .led_run(led_run), .led_fetch(led_fetch), .led_defer(led_defer), .led_exec(led_exec)
    );

    // Processor, register and memory model.
    always @(posedge clk) begin
        if (!rst_n) begin
            pc_m <= 8'h00; ma_m <= 8'h00; mb_m <= 8'h00; rdata_m <= 8'h00;
            phase_m <= 2'b00; instr_done <= 0;
        end else begin
            if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_req && !mem_we) rdata_m <= mem[mem_addr];
            if (ma_wr_en) ma_m <= ma_wr_val;
            if (mb_wr_en) mb_m <= mb_wr_val;
            if (pc_wr_en) pc_m <= pc_wr_val;
            else if (cpu_ce && phase_m == 2'b10) pc_m <= pc_m + 8'h01;
            if (cpu_ce) begin
                case (phase_m)
                    2'b00:   phase_m <= defer_mode ? 2'b01 : 2'b10;
                    2'b01:   phase_m <= 2'b10;
                    default: begin phase_m <= 2'b00; instr_done <= instr_done + 1; end
                endcase
            end
        end
        if (rst_n && (mem_req || pc_wr_en || ma_wr_en || mb_wr_en))
            console_acts <= console_acts + 1;
    end

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic set_btn(input int which, input logic v);
        case (which)
            0: btn_load = v;
            1: btn_deposit = v;
            2: btn_examine = v;
            3: btn_run = v;
            default: btn_halt = v;
        endcase
    endtask

    task automatic press(input int which, input int hold);
        @(negedge clk); set_btn(which, 1'b1);
        repeat (hold) @(negedge clk);
        set_btn(which, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic set_pc(input logic [7:0] v);
        sw_data = v; press(0, 1);
    endtask

    task automatic start_run();
        int n = 0;
        @(negedge clk); btn_run = 1'b1;
        @(negedge clk); btn_run = 1'b0;
        while (!cpu_run && n < 10) begin @(negedge clk); n++; end
    endtask

    task automatic wait_stop(input string req);
        int n = 0;
        while (cpu_run && n < 100) begin @(negedge clk); n++; end
        check(req, cpu_run, 0);
    endtask

    task automatic t_reset();
        check("R1 run", cpu_run, 0);
        check("R1 ce", cpu_ce, 0);
        check("R1 requests", {mem_req, pc_wr_en, ma_wr_en, mb_wr_en}, 0);
        check("R1 lamps", {led_run, led_fetch, led_defer, led_exec}, 0);
    endtask

    task automatic t_load();
        set_pc(8'hA5);
        check("R2 pc", pc_m, 8'hA5);
        set_pc(8'h07);
        check("R2 pc second", pc_m, 8'h07);
    endtask

    task automatic t_deposit();
        set_pc(8'h3C);
        sw_data = 8'h5E; press(1, 1);
        check("R3 mem", mem[8'h3C], 8'h5E);
        check("R3 ma", ma_m, 8'h3C);
        check("R3 pc", pc_m, 8'h3D);
        set_pc(8'hFF);
        sw_data = 8'h77; press(1, 1);
        check("R3 mem top", mem[8'hFF], 8'h77);
        check("R3 pc wrap", pc_m, 8'h00);
    endtask

    task automatic t_examine();
        set_pc(8'h40);
        press(2, 1);
        check("R4 mb", mb_m, 8'h9B);
        check("R4 ma", ma_m, 8'h40);
        check("R4 pc", pc_m, 8'h41);
    endtask

    task automatic t_held();
        set_pc(8'h10);
        sw_data = 8'h11; press(1, 12);
        check("R5 pc", pc_m, 8'h11);
        check("R5 mem written", mem[8'h10], 8'h11);
        check("R5 next untouched", mem[8'h11], 8'hEE);
    endtask

    task automatic t_priority();
        logic [7:0] mb_before;
        set_pc(8'h20);
        sw_data = 8'h55;
        @(negedge clk); btn_load = 1'b1; btn_deposit = 1'b1;
        @(negedge clk); btn_load = 1'b0; btn_deposit = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 load wins pc", pc_m, 8'h55);
        check("R6 no store", mem[8'h20], 8'h00);
        mb_before = mb_m;
        sw_data = 8'h66;
        @(negedge clk); btn_deposit = 1'b1; btn_examine = 1'b1;
        @(negedge clk); btn_deposit = 1'b0; btn_examine = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 store wins mem", mem[8'h55], 8'h66);
        check("R6 store wins pc", pc_m, 8'h56);
        check("R6 no peek", mb_m, mb_before);
    endtask

    task automatic t_single();
        int d0;
        mode_single = 1'b1; mode_slow = 1'b0; defer_mode = 1'b1;
        set_pc(8'h30);
        d0 = instr_done;
        start_run();
        repeat (12) @(negedge clk);
        check("R10 stopped", cpu_run, 0);
        check("R10 one instr", instr_done - d0, 1);
        check("R10 pc", pc_m, 8'h31);
        check("R10 phase", phase_m, 0);
        mode_single = 1'b0;
    endtask

    task automatic t_cont_fast();
        int ces = 0, lamp_err = 0, d0, acts0;
        logic [7:0] pc0;
        defer_mode = 1'b0; mode_slow = 1'b0;
        set_pc(8'h60);
        pc0 = pc_m; d0 = instr_done;
        start_run();
        for (int i = 0; i < 10; i++) begin
            if (cpu_ce) ces++;
            if (led_run !== 1'b1 || led_fetch !== (phase_m == 2'b00) ||
                led_defer !== (phase_m == 2'b01) || led_exec !== (phase_m == 2'b10))
                lamp_err++;
            @(negedge clk);
        end
        check("R8 ce every cycle", ces, 10);
        check("R13 lamps running", lamp_err, 0);
        acts0 = console_acts;
        sw_data = 8'hC3; press(1, 1);
        press(0, 1);
        press(2, 1);
        check("R7 no console action", console_acts - acts0, 0);
        check("R7 still running", cpu_run, 1);
        press(4, 1);
        wait_stop("R9 stop");
        check("R9 phase fetch", phase_m, 0);
        check("R9 pc next", pc_m, 8'(pc0 + (instr_done - d0)));
        check("R13 lamps off", {led_run, led_fetch, led_defer, led_exec}, 0);
    endtask

    task automatic t_slow();
        int ces = 0;
        defer_mode = 1'b1; mode_slow = 1'b1;
        set_pc(8'h80);
        start_run();
        for (int i = 0; i < 20; i++) begin
            if (cpu_ce) ces++;
            @(negedge clk);
        end
        check("R11 slow pulses", ces, 4);
        btn_halt = 1'b1;
        @(negedge clk); btn_halt = 1'b0;
        @(negedge clk);
        check("R9 runs to boundary", cpu_run, 1);
        check("R9 mid phase", phase_m, 1);
        wait_stop("R9 slow stop");
        check("R9 slow phase fetch", phase_m, 0);
        mode_slow = 1'b0;
    endtask

    task automatic t_hlt();
        int d0;
        defer_mode = 1'b0; hlt_arm = 1'b1;
        set_pc(8'h90);
        d0 = instr_done;
        start_run();
        wait_stop("R12 stop");
        check("R12 one instr", instr_done - d0, 1);
        check("R12 pc next", pc_m, 8'h91);
        hlt_arm = 1'b0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; sw_data = 8'h00;
        btn_load = 0; btn_deposit = 0; btn_examine = 0; btn_run = 0; btn_halt = 0;
        mode_single = 0; mode_slow = 0; defer_mode = 0; hlt_arm = 0;
        console_acts = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h40] = 8'h9B;
        mem[8'h11] = 8'hEE;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_deposit();
        t_examine();
        t_held();
        t_priority();
        t_single();
        t_cont_fast();
        t_slow();
        t_hlt();
        finish_up();
    end

endmodule